// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the arithmetic and logic stage of a small 32-bit processor datapath. Each cycle in which the execute strobe is high, it takes an operation code, a first operand, an already-shifted second operand and the carry that the shifter produced. It computes one of fourteen operations: two moves, four add/subtract forms (one of them reverse subtract, one add-with-carry), four bitwise operations (one of them bit clear), and four compare/test forms. The result and its write-enable are registered and appear one cycle after the strobe.

A four-bit condition register holds the negative, zero, carry and overflow flags. An ordinary operation updates this register only when its set-flags input is high. The compare and test forms always update it, and they never assert the write-enable. Add-with-carry reads the carry flag held in the register, so a wide sum can be built from a sequence of 32-bit steps. Decoding, shifting, immediate generation, conditional execution and the register file sit outside this block.

Top module: `dp_alu`

## Requirements
- R1: The operation code is 4 bits: AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. When `exec_en` is high at a rising edge and the code is a writing operation (any code other than 6 to 11), `result` and `result_we` reflect that operation after that edge. At all other times `result` keeps its previous value.
- R2: MOV yields `op2` and MVN yields the bitwise inverse of `op2`. Neither depends on `rn`.
- R3: ADD yields `rn + op2`. ADC yields `rn + op2 + C`, where C is the carry flag held before the operation.
- R4: SUB yields `rn - op2`. RSB yields `op2 - rn`, so RSB with `op2 = 0` negates `rn`.
- R5: AND, ORR and EOR yield the bitwise AND, OR and XOR of `rn` and `op2`. BIC yields `rn & ~op2`.
- R6: When `set_flags` is low, a writing operation leaves all four flags unchanged.
- R7: On a flag update, N equals bit 31 of the computed value, and Z is 1 exactly when all 32 bits of that value are zero.
- R8: For ADD, ADC and CMN, C is the carry out of bit 31. For SUB, RSB and CMP, C is 1 when no borrow occurs. For all six, V is 1 on signed two's-complement overflow.
- R9: On a flag update by a logic or move operation (including TST and TEQ), C takes `shift_carry` and V keeps its previous value.
- R10: TST, TEQ, CMP and CMN update the flags from `rn & op2`, `rn ^ op2`, `rn - op2` and `rn + op2` whatever `set_flags` is. They drive `result_we` low and leave `result` unchanged.
- R11: Codes 6 and 7 write nothing and change no flag.
- R12: After reset, `result` is 0, `result_we` is 0 and all four flags are 0.
- R13: When `exec_en` is low at an edge, `result_we` is 0 after it, and neither `result` nor the flags change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe: perform the operation this cycle |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Update flags from a writing operation |
| rn | input | 32 | First operand |
| op2 | input | 32 | Second (pre-shifted) operand |
| shift_carry | input | 1 | Carry out of the external shifter |
| result | output | 32 | Registered result |
| result_we | output | 1 | Registered result write-enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The bench targets the wrap cases: all-ones plus one, equal operands in a subtraction, zero minus one, and the largest positive value plus one. A design that inverted the borrow sense, or that took the carry for overflow, gets the C or V flag wrong in exactly these cases. A two-word add-with-carry chain shows whether ADC reads the held carry. An RSB negation would come out with the wrong sign if the operands were swapped. A logic operation run after an overflow shows whether V is held or wrongly cleared. Compares run with set-flags low, the reserved codes, and idle cycles catch a design that writes results or touches flags when it should not.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_EOR  = 4'd1,
    OP_SUB  = 4'd2,
    OP_RSB  = 4'd3,
    OP_ADD  = 4'd4,
    OP_ADC  = 4'd5,
    OP_RSV6 = 4'd6,
    OP_RSV7 = 4'd7,
    OP_TST  = 4'd8,
    OP_TEQ  = 4'd9,
    OP_CMP  = 4'd10,
    OP_CMN  = 4'd11,
    OP_ORR  = 4'd12,
    OP_MOV  = 4'd13,
    OP_BIC  = 4'd14,
    OP_MVN  = 4'd15
  } dp_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } dp_flags_t;

  function automatic logic op_is_arith(input dp_op_e op);
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_CMP, OP_CMN: op_is_arith = 1'b1;
      default: op_is_arith = 1'b0;
    endcase
  endfunction

  function automatic logic op_is_compare(input dp_op_e op);
    case (op)
      OP_TST, OP_TEQ, OP_CMP, OP_CMN: op_is_compare = 1'b1;
      default: op_is_compare = 1'b0;
    endcase
  endfunction

  function automatic logic op_is_reserved(input dp_op_e op);
    op_is_reserved = (op == OP_RSV6) || (op == OP_RSV7);
  endfunction

endpackage

// File: rtl/dp_addsub.sv
module dp_addsub
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  dp_op_e         op,
  input  logic [W-1:0]   rn,
  input  logic [W-1:0]   op2,
  input  logic           carry_in,
  output logic [W-1:0]   sum,
  output logic           cout,
  output logic           ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] a_opd;
  logic [W-1:0] b_opd;
  logic         cin;
  logic [W:0]   wide;

  // Subtractions are formed as a + ~b + 1, so the carry out is "no borrow".
  always_comb begin
    a_opd = rn;
    b_opd = op2;
    cin   = 1'b0;
    case (op)
      OP_SUB, OP_CMP: begin
        b_opd = ~op2;
        cin   = 1'b1;
      end
      OP_RSB: begin
        a_opd = op2;
        b_opd = ~rn;
        cin   = 1'b1;
      end
      OP_ADC: cin = carry_in;
      default: cin = 1'b0;
    endcase
  end

  assign wide = {1'b0, a_opd} + {1'b0, b_opd} + {{W{1'b0}}, cin};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  assign ovf  = (a_opd[MSB] == b_opd[MSB]) && (sum[MSB] != a_opd[MSB]);

endmodule

// File: rtl/dp_bitwise.sv
module dp_bitwise
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  dp_op_e       op,
  input  logic [W-1:0] rn,
  input  logic [W-1:0] op2,
  output logic [W-1:0] out
);
  always_comb begin
    case (op)
      OP_AND, OP_TST: out = rn & op2;
      OP_EOR, OP_TEQ: out = rn ^ op2;
      OP_ORR:         out = rn | op2;
      OP_BIC:         out = rn & ~op2;
      OP_MOV:         out = op2;
      OP_MVN:         out = ~op2;
      default:        out = '0;
    endcase
  end
endmodule

// File: rtl/dp_flag_reg.sv
module dp_flag_reg
  import dp_alu_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  dp_flags_t d,
  output dp_flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec_en,
  input  logic [3:0]   opcode,
  input  logic         set_flags,
  input  logic [W-1:0] rn,
  input  logic [W-1:0] op2,
  input  logic         shift_carry,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);
  localparam int MSB = W - 1;

  dp_op_e    op;
  logic      is_arith;
  logic      is_cmp;
  logic      is_rsv;
  logic      writes;
  logic      flag_load;
  logic [W-1:0] add_res;
  logic      add_cout;
  logic      add_ovf;
  logic [W-1:0] log_res;
  logic [W-1:0] alu_res;
  dp_flags_t flags_d;
  dp_flags_t flags_q;
  logic [W-1:0] res_q;
  logic      we_q;

  assign op       = dp_op_e'(opcode);
  assign is_arith = op_is_arith(op);
  assign is_cmp   = op_is_compare(op);
  assign is_rsv   = op_is_reserved(op);
  assign writes   = !is_cmp && !is_rsv;

  dp_addsub #(.W(W)) u_addsub (
    .op       (op),
    .rn       (rn),
    .op2      (op2),
    .carry_in (flags_q.c),
    .sum      (add_res),
    .cout     (add_cout),
    .ovf      (add_ovf)
  );

  dp_bitwise #(.W(W)) u_bitwise (
    .op  (op),
    .rn  (rn),
    .op2 (op2),
    .out (log_res)
  );

  assign alu_res = is_arith ? add_res : log_res;

  always_comb begin
    flags_d.n = alu_res[MSB];
    flags_d.z = ~|alu_res;
    flags_d.c = is_arith ? add_cout : shift_carry;
    flags_d.v = is_arith ? add_ovf  : flags_q.v;
  end

  assign flag_load = exec_en && !is_rsv && (is_cmp || set_flags);

  dp_flag_reg u_flags (
    .clk  (clk),
    .rst  (rst),
    .load (flag_load),
    .d    (flags_d),
    .q    (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      we_q  <= 1'b0;
    end else begin
      we_q <= exec_en && writes;
      if (exec_en && writes) res_q <= alu_res;
    end
  end

  assign result    = res_q;
  assign result_we = we_q;
  assign flag_n    = flags_q.n;
  assign flag_z    = flags_q.z;
  assign flag_c    = flags_q.c;
  assign flag_v    = flags_q.v;

  AST_HOLD_NO_S: assert property (@(posedge clk) disable iff (rst)
    exec_en && !set_flags && !is_cmp |=> $stable(flags_q)); // R6

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    exec_en && is_cmp |=> !result_we && $stable(result)); // R10

  AST_RSV_QUIET: assert property (@(posedge clk) disable iff (rst)
    exec_en && is_rsv |=> !result_we && $stable(flags_q) && $stable(result)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> !result_we && $stable(flags_q) && $stable(result)); // R13

  AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
    result_we && $past(set_flags) |-> (flag_n == result[MSB]) && (flag_z == (result == '0))); // R7

  AST_LOGIC_V_HOLD: assert property (@(posedge clk) disable iff (rst)
    exec_en && !is_arith && !is_rsv |=> $stable(flag_v)); // R9

endmodule

// File: tb/dp_alu_test.sv
module dp_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_en = 1'b0;
  logic [3:0]  opcode = 4'd0;
  logic        set_flags = 1'b0;
  logic [31:0] rn = '0;
  logic [31:0] op2 = '0;
  logic        shift_carry = 1'b0;
  logic [31:0] result;
  logic        result_we;
  logic        flag_n, flag_z, flag_c, flag_v;

  int n_checks = 0;
  int n_fail = 0;

  logic [31:0] m_res = '0;
  logic [3:0]  m_flags = 4'b0000; // {N,Z,C,V}

  dp_alu #(.W(32)) uut (
    .clk(clk), .rst(rst), .exec_en(exec_en), .opcode(opcode),
    .set_flags(set_flags), .rn(rn), .op2(op2), .shift_carry(shift_carry),
    .result(result), .result_we(result_we),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic sovf(input longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  // Reference model step. Outputs expected we, result and flags.
  task automatic run_op(input logic [3:0] op, input logic s, input logic [31:0] a,
                        input logic [31:0] b, input logic sc);
    logic [31:0] r;
    logic        c, v, arith, cmp, rsv, we, upd;
    longint      sa, sb;
    logic [32:0] w;
    string       rtag, ftag;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    arith = 1'b0; c = sc; v = m_flags[0]; r = '0;
    rtag = "R5";
    case (op)
      4'd0, 4'd8:  r = a & b;
      4'd1, 4'd9:  r = a ^ b;
      4'd12:       r = a | b;
      4'd14:       r = a & ~b;
      4'd13: begin r = b;  rtag = "R2"; end
      4'd15: begin r = ~b; rtag = "R2"; end
      4'd2, 4'd10: begin r = a - b; c = (a >= b); v = sovf(sa - sb); arith = 1'b1; rtag = "R4"; end
      4'd3:        begin r = b - a; c = (b >= a); v = sovf(sb - sa); arith = 1'b1; rtag = "R4"; end
      4'd4, 4'd11: begin w = {1'b0, a} + {1'b0, b}; r = w[31:0]; c = w[32]; v = sovf(sa + sb);
                         arith = 1'b1; rtag = "R3"; end
      4'd5: begin w = {1'b0, a} + {1'b0, b} + {32'd0, m_flags[1]}; r = w[31:0]; c = w[32];
                  v = sovf(sa + sb + longint'(m_flags[1])); arith = 1'b1; rtag = "R3"; end
      default: r = '0;
    endcase
    cmp = (op >= 4'd8) && (op <= 4'd11);
    rsv = (op == 4'd6) || (op == 4'd7);
    we  = !cmp && !rsv;
    upd = !rsv && (cmp || s);
    if (cmp) rtag = "R10";
    if (rsv) rtag = "R11";
    ftag = !upd ? (rsv ? "R11" : "R6") : (arith ? "R8" : "R9");

    @(negedge clk);
    opcode = op; set_flags = s; rn = a; op2 = b; shift_carry = sc; exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;

    if (we) m_res = r;
    if (upd) m_flags = {r[31], (r == 32'd0), c, v};
    check(we ? "R1 write-enable" : {rtag, " write-enable"}, {31'd0, result_we}, {31'd0, we});
    check({rtag, " result"}, result, m_res);
    check({ftag, " R7 flags NZCV"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, m_flags});
  endtask

  task automatic idle_cycle;
    @(negedge clk);
    opcode = 4'($urandom); set_flags = 1'b1; rn = $urandom; op2 = $urandom;
    shift_carry = 1'($urandom); exec_en = 1'b0;
    @(negedge clk);
    check("R13 idle write-enable", {31'd0, result_we}, 32'd0);
    check("R13 idle result", result, m_res);
    check("R13 idle flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, m_flags});
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A1F));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R12 reset result", result, 32'd0);
    check("R12 reset write-enable", {31'd0, result_we}, 32'd0);
    check("R12 reset flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);

    // Directed corners
    run_op(4'd13, 1'b1, 32'h1234_5678, 32'h0, 1'b1);          // R2 MOV zero -> Z, C from shifter
    run_op(4'd15, 1'b1, 32'hDEAD_BEEF, 32'h0, 1'b0);          // R2 MVN -> all ones, N
    run_op(4'd4,  1'b1, 32'hFFFF_FFFF, 32'h1, 1'b0);          // R3/R8 wrap: Z, C
    run_op(4'd5,  1'b1, 32'h0000_0001, 32'h0000_0002, 1'b0);  // R3 ADC uses C=1 -> 4
    run_op(4'd4,  1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0);  // low word carry
    run_op(4'd5,  1'b0, 32'h0000_0003, 32'h0000_0004, 1'b0);  // R3 high word + carry, R6 flags held
    run_op(4'd2,  1'b1, 32'h0000_0055, 32'h0000_0055, 1'b0);  // R4/R8 equal: Z, C=1
    run_op(4'd2,  1'b1, 32'h0, 32'h1, 1'b1);                  // R8 borrow: C=0, N
    run_op(4'd3,  1'b1, 32'd5, 32'd0, 1'b0);                  // R4 RSB negate
    run_op(4'd4,  1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0);          // R8 V set
    run_op(4'd14, 1'b1, 32'h0000_00FF, 32'h0000_000F, 1'b0);  // R5 BIC, R9 V held
    run_op(4'd12, 1'b0, 32'h0F0F_0000, 32'h0000_F0F0, 1'b1);  // R6 no S
    run_op(4'd10, 1'b0, 32'd7, 32'd7, 1'b0);                  // R10 CMP with S low
    run_op(4'd11, 1'b0, 32'hFFFF_FFFF, 32'd1, 1'b0);          // R10 CMN
    run_op(4'd8,  1'b0, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b1);  // R10 TST zero
    run_op(4'd9,  1'b0, 32'h8000_0001, 32'h0000_0001, 1'b0);  // R10 TEQ negative
    run_op(4'd6,  1'b1, 32'h1, 32'h2, 1'b1);                  // R11
    run_op(4'd7,  1'b1, 32'h0, 32'h0, 1'b0);                  // R11
    idle_cycle();                                             // R13

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      case ($urandom % 6)
        0: a = 32'h0;
        1: b = a;
        2: b = 32'hFFFF_FFFF;
        3: a = 32'h7FFF_FFFF;
        default: ;
      endcase
      run_op(4'($urandom), 1'($urandom), a, b, 1'($urandom));
      if (($urandom % 10) == 0) idle_cycle();
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule